// File: doc/BRIEF.md
# Transponder Read Stream Sequencer

This block decides, one field clock at a time, which memory bit a contactless transponder sends back to the reader. After reset it reads the configuration word from block 0 for a fixed start-up window with modulation held off. It then sends data blocks in a fixed cycle, optionally adding terminator patterns that the reader can lock onto. It reloads its mode from block 0 at the start of every block, so a mode that was captured wrongly corrects itself.

The sequencer also applies the transponder's silence rules. With answer-on-request set it stays quiet until a wake-up arrives. A stop command that is obeyed silences it until the next reset. When a field gap starts a write, it stops sending until the command decoder reports how the write ended. It then resumes at the block just programmed, or at the first block after a failed write. The EEPROM array, the command decoder and the modulation encoders are outside this block. The sequencer drives a read address, samples the returned word, and gives the modulator a data bit, a bit-start strobe, a terminator flag and an enable.

Top module: `rs_seq_top`

## Requirements
- R1: After reset, `mod_en` and `bit_start` stay low while block 0 is read for INIT_CYC (256) field clocks. The first bit period starts on the 258th clock edge after reset is released.
- R2: A high `gap` during the start-up window restarts the full INIT_CYC count.
- R3: Blocks are sent from block 1 up to the last-block field, then the cycle wraps to block 1. Each block sends word bits 1 to 32 in that order, one per bit period. Bit 0, the lock bit, is never sent.
- R4: When the last-block field is 0, block 0 is sent on every pass and the sequence terminator is left out, even if it is enabled.
- R5: When the block-terminator bit is set, every block is preceded by a terminator. A terminator is one bit period with `tx_bit`=1, followed by one bit period with `tx_bit`=0, with `term_active` high for both.
- R6: When the sequence-terminator bit is set, two terminators (4 bit periods) follow the last block of each pass.
- R7: The mode is reloaded from block 0 before every block, so a change to block 0 takes effect within one block.
- R8: The bit period in field clocks follows rate code bits [10:8]: codes 0 to 7 select 8, 16, 32, 40, 50, 64, 100 and 128.
- R9: With the answer-on-request bit set, `mod_en` stays low after start-up until a `wake` pulse arrives during a write. Sending then starts again at block 1.
- R10: `stop_cmd` during a write holds `mod_en` low until reset. If stop-ignore bit [7] is 1, the stop is ignored, modulation resumes, and sending restarts at block 1.
- R11: `prog_done` resumes sending at `prog_blk`. The resumed block is preceded by one terminator if either terminator bit was set in the current mode. When `prog_blk` is 0, that block is sent under the previous mode, and the new mode applies from the next block.
- R12: `wr_err` resumes sending at block 1, or at block 0 when the last-block field is 0.
- R13: A `gap` after start-up enters a write hold, and `mod_en` stays low until a decoder event ends it.

Configuration word layout in block 0: bit 0 is the lock bit; [3:1] last block; [4] block terminator enable; [5] sequence terminator enable; [6] answer-on-request; [7] stop-ignore; [10:8] rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| gap | input | 1 | Field gap detected |
| wake | input | 1 | Valid wake-up command (pulse) |
| stop_cmd | input | 1 | Valid stop command (pulse) |
| prog_done | input | 1 | Programming finished or aborted (pulse) |
| prog_blk | input | 3 | Block addressed by the write |
| wr_err | input | 1 | Write stream rejected (pulse) |
| rd_addr | output | 3 | Memory block read address |
| rd_word | input | 33 | Word read from `rd_addr`, same cycle |
| tx_bit | output | 1 | Current serial bit for the modulator |
| mod_en | output | 1 | Modulation enable |
| term_active | output | 1 | A terminator is being sent |
| bit_start | output | 1 | First field clock of a bit period |

## Verification
The stream is recorded one symbol per `bit_start`. Each symbol holds the terminator flag, the bit value and the block address, and is compared with a sequence built from the memory contents and the configuration. Directed runs cover last-block values of 0, 2 and 3, each terminator setting, and a slow rate. Together they separate wrap errors, wrong bit order, misplaced terminators and a wrong bit period. Random configurations and random memory words then test the last-block and terminator logic against each other. Resume tests enter a write with a gap and end it with each decoder event. The first symbols after resuming show whether the restart block, the leading terminator and the old-mode rule for block 0 are right, and whether a stop holds.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int CFG_W  = 10;
    localparam int RATE_W = 8;

    typedef enum logic [2:0] {
        S_INIT,
        S_CFG,
        S_FETCH,
        S_TERM,
        S_DATA,
        S_WRITE
    } rs_state_e;

    typedef struct packed {
        logic [2:0] rate;
        logic       stop_ign;
        logic       aor;
        logic       use_st;
        logic       use_bt;
        logic [2:0] last_blk;
    } rs_mode_t;

    // cfg holds word bits [10:1]
    function automatic rs_mode_t decode_mode(input logic [CFG_W-1:0] cfg);
        rs_mode_t m;
        m.last_blk = cfg[2:0];
        m.use_bt   = cfg[3];
        m.use_st   = cfg[4];
        m.aor      = cfg[5];
        m.stop_ign = cfg[6];
        m.rate     = cfg[9:7];
        return m;
    endfunction

    function automatic logic [RATE_W-1:0] cycles_per_bit(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd8;
            3'd1:    return 8'd16;
            3'd2:    return 8'd32;
            3'd3:    return 8'd40;
            3'd4:    return 8'd50;
            3'd5:    return 8'd64;
            3'd6:    return 8'd100;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/rs_bit_timer.sv
module rs_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             bit_start,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt;

    assign bit_start = run && (cnt == '0);
    assign bit_end   = run && (cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (bit_end) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    a_r8_count_in_period: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < period));
endmodule

// File: rtl/rs_mod_gate.sv
module rs_mod_gate (
    input  logic clk,
    input  logic rst,
    input  logic set_wake,
    input  logic set_stop,
    input  logic aor,
    output logic allow
);
    logic awake_q;
    logic stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            awake_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            if (set_wake) awake_q <= 1'b1;
            if (set_stop) stop_q  <= 1'b1;
        end
    end

    assign allow = !stop_q && (!aor || awake_q);

    a_r10_stop_sticky: assert property (@(posedge clk) disable iff (rst)
        stop_q |=> stop_q);
endmodule

// File: rtl/rs_seq_top.sv
module rs_seq_top
    import rs_pkg::*;
#(
    parameter int INIT_CYC = 256,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gap,
    input  logic              wake,
    input  logic              stop_cmd,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] prog_blk,
    input  logic              wr_err,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W:0]   rd_word,
    output logic              tx_bit,
    output logic              mod_en,
    output logic              term_active,
    output logic              bit_start
);
    localparam int INIT_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
    localparam int IDX_W  = $clog2(DATA_W + 1);

    rs_state_e         st_q;
    rs_mode_t          mode_q;
    rs_mode_t          cfg_now;
    logic [INIT_W-1:0] init_cnt;
    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] first_blk;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W:0]   data_q;
    logic [2:0]        term_cnt;
    logic [2:0]        term_len;
    logic              term_then_data;
    logic              force_bt;
    logic              skip_reload;
    logic              is_last;
    logic              run;
    logic              bit_end;
    logic              allow;
    logic              in_stream;

    assign cfg_now   = decode_mode(rd_word[CFG_W:1]);
    assign first_blk = (mode_q.last_blk == '0) ? '0 : ADDR_W'(1);
    assign is_last   = (mode_q.last_blk == '0) || (blk_q >= ADDR_W'(mode_q.last_blk));
    assign run       = (st_q == S_TERM) || (st_q == S_DATA);
    assign in_stream = (st_q == S_CFG) || (st_q == S_FETCH) || run;

    rs_bit_timer #(.CNT_W(RATE_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .period    (cycles_per_bit(mode_q.rate)),
        .bit_start (bit_start),
        .bit_end   (bit_end)
    );

    rs_mod_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .set_wake (st_q == S_WRITE && wake),
        .set_stop (st_q == S_WRITE && stop_cmd && !mode_q.stop_ign),
        .aor      (mode_q.aor),
        .allow    (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= S_INIT;
            mode_q         <= '0;
            init_cnt       <= '0;
            blk_q          <= ADDR_W'(1);
            bit_idx        <= IDX_W'(1);
            data_q         <= '0;
            term_cnt       <= '0;
            term_len       <= 3'd2;
            term_then_data <= 1'b0;
            force_bt       <= 1'b0;
            skip_reload    <= 1'b0;
        end else if (in_stream && gap) begin
            st_q <= S_WRITE;
        end else begin
            case (st_q)
                S_INIT: begin
                    if (gap) begin
                        init_cnt <= '0;
                    end else if (init_cnt == INIT_W'(INIT_CYC - 1)) begin
                        mode_q <= cfg_now;
                        blk_q  <= (cfg_now.last_blk == '0) ? '0 : ADDR_W'(1);
                        st_q   <= S_CFG;
                    end else begin
                        init_cnt <= init_cnt + 1'b1;
                    end
                end
                S_CFG: begin
                    if (!skip_reload) mode_q <= cfg_now;
                    skip_reload <= 1'b0;
                    st_q        <= S_FETCH;
                end
                S_FETCH: begin
                    data_q   <= rd_word;
                    bit_idx  <= IDX_W'(1);
                    force_bt <= 1'b0;
                    if (force_bt || mode_q.use_bt) begin
                        term_cnt       <= '0;
                        term_len       <= 3'd2;
                        term_then_data <= 1'b1;
                        st_q           <= S_TERM;
                    end else begin
                        st_q <= S_DATA;
                    end
                end
                S_TERM: begin
                    if (bit_end) begin
                        if (term_cnt == term_len - 1'b1)
                            st_q <= term_then_data ? S_DATA : S_CFG;
                        else
                            term_cnt <= term_cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (bit_end) begin
                        if (bit_idx == IDX_W'(DATA_W)) begin
                            if (is_last) begin
                                blk_q <= first_blk;
                                if (mode_q.use_st && mode_q.last_blk != '0) begin
                                    term_cnt       <= '0;
                                    term_len       <= 3'd4;
                                    term_then_data <= 1'b0;
                                    st_q           <= S_TERM;
                                end else begin
                                    st_q <= S_CFG;
                                end
                            end else begin
                                blk_q <= blk_q + 1'b1;
                                st_q  <= S_CFG;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                S_WRITE: begin
                    if (prog_done) begin
                        blk_q       <= prog_blk;
                        force_bt    <= mode_q.use_bt || mode_q.use_st;
                        skip_reload <= (prog_blk == '0);
                        st_q        <= S_CFG;
                    end else if (wr_err || wake || stop_cmd) begin
                        blk_q <= first_blk;
                        st_q  <= S_CFG;
                    end
                end
                default: st_q <= S_INIT;
            endcase
        end
    end

    always_comb begin
        rd_addr = (st_q == S_INIT || st_q == S_CFG) ? '0 : blk_q;
        case (st_q)
            S_TERM:  tx_bit = !term_cnt[0];
            S_DATA:  tx_bit = data_q[bit_idx];
            default: tx_bit = 1'b0;
        endcase
    end

    assign term_active = (st_q == S_TERM);
    assign mod_en      = allow && (st_q != S_INIT) && (st_q != S_WRITE);

    a_r1_init_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_INIT) |-> (!mod_en && !bit_start));
    a_r13_write_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WRITE) |-> !mod_en);
    a_r3_bit_in_range: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DATA) |-> (bit_idx >= IDX_W'(1) && bit_idx <= IDX_W'(DATA_W)));
    a_r6_term_bounded: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TERM) |-> (term_cnt < term_len));
    a_r4_no_seq_term_at_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TERM && term_len == 3'd4) |-> (mode_q.last_blk != '0));
    a_r7_mode_only_at_cfg: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_CFG && st_q != S_INIT) |=> $stable(mode_q));
endmodule

// File: tb/sim_rs_seq_top.sv
module sim_rs_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gap = 1'b0, wake = 1'b0, stop_cmd = 1'b0, prog_done = 1'b0, wr_err = 1'b0;
    logic [2:0]  prog_blk = '0;
    logic [2:0]  rd_addr;
    logic [32:0] rd_word;
    logic        tx_bit, mod_en, term_active, bit_start;

    logic [32:0] mem [0:7];
    assign rd_word = mem[rd_addr];

    always #2 clk = ~clk;

    rs_seq_top u0 (
        .clk(clk), .rst(rst), .gap(gap), .wake(wake), .stop_cmd(stop_cmd),
        .prog_done(prog_done), .prog_blk(prog_blk), .wr_err(wr_err),
        .rd_addr(rd_addr), .rd_word(rd_word), .tx_bit(tx_bit), .mod_en(mod_en),
        .term_active(term_active), .bit_start(bit_start)
    );

    int checks = 0, fails = 0, cyc = 0;
    localparam int MAXS = 512;
    logic    s_term [0:MAXS-1];
    logic    s_bit  [0:MAXS-1];
    int      s_blk  [0:MAXS-1];
    int      s_cyc  [0:MAXS-1];
    logic    e_term [0:MAXS-1];
    logic    e_bit  [0:MAXS-1];
    int      e_blk  [0:MAXS-1];
    int      nsym = 0;
    logic    cap_on = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cap_on && bit_start && nsym < MAXS) begin
            s_term[nsym] <= term_active;
            s_bit[nsym]  <= tx_bit;
            s_blk[nsym]  <= int'(rd_addr);
            s_cyc[nsym]  <= cyc;
            nsym         <= nsym + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] mk_cfg(input int last, input bit bt, input bit sq,
                                           input bit aor, input bit ign, input int rate);
        logic [32:0] w;
        w = {$urandom, 1'b0};
        w[0]    = $urandom_range(0, 1);
        w[3:1]  = 3'(last);
        w[4]    = bt;
        w[5]    = sq;
        w[6]    = aor;
        w[7]    = ign;
        w[10:8] = 3'(rate);
        return w;
    endfunction

    task automatic fill_mem();
        for (int i = 1; i < 8; i++) mem[i] = {$urandom, 1'($urandom_range(0, 1))};
    endtask

    int ne;
    task automatic push(input logic t, input logic b, input int blk);
        if (ne < MAXS) begin
            e_term[ne] = t; e_bit[ne] = b; e_blk[ne] = blk; ne++;
        end
    endtask

    task automatic build_exp(input int start, input int last, input bit bt, input bit sq,
                             input bit lead, input int n);
        int b;
        bit first;
        b = start; first = 1; ne = 0;
        while (ne < n) begin
            if (bt || (first && lead)) begin push(1, 1, b); push(1, 0, b); end
            first = 0;
            for (int i = 1; i <= 32; i++) push(0, mem[b][i], b);
            if (last == 0 || b >= last) begin
                if (sq && last != 0) begin
                    push(1, 1, b); push(1, 0, b); push(1, 1, b); push(1, 0, b);
                end
                b = (last == 0) ? 0 : 1;
            end else b++;
        end
    endtask

    task automatic compare(input int n, input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < n; i++) begin
            if (bad < 0 && (s_term[i] !== e_term[i] || s_bit[i] !== e_bit[i] ||
                            (!e_term[i] && s_blk[i] != e_blk[i]))) bad = i;
        end
        if (bad >= 0)
            chk(0, tag, {s_term[bad], s_bit[bad]} * 100 + s_blk[bad],
                {e_term[bad], e_bit[bad]} * 100 + e_blk[bad]);
        else chk(1, tag, 0, 0);
    endtask

    task automatic start_cap();
        cap_on = 1'b0;
        @(negedge clk);
        nsym = 0;
        cap_on = 1'b1;
    endtask

    task automatic wait_syms(input int n, input string tag);
        int t;
        t = 0;
        while (nsym < n && t < 40000) begin @(negedge clk); t++; end
        if (nsym < n) chk(0, tag, nsym, n);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; gap = 0; wake = 0; stop_cmd = 0; prog_done = 0; wr_err = 0;
        cap_on = 1'b0;
        repeat (3) @(negedge clk);
        nsym = 0;
        cap_on = 1'b1;
        rst = 1'b0;
    endtask

    task automatic boot(input logic [32:0] cfg);
        mem[0] = cfg;
        do_reset();
        repeat (260) @(negedge clk);
    endtask

    // 0 gap only, 1 wake, 2 stop, 3 wr_err, 4 prog_done
    task automatic write_event(input int kind, input int blk);
        @(negedge clk); gap = 1'b1;
        @(negedge clk); gap = 1'b0;
        repeat (5) @(negedge clk);
        cap_on = 1'b0; nsym = 0; cap_on = 1'b1;
        prog_blk = 3'(blk);
        case (kind)
            1: wake = 1'b1;
            2: stop_cmd = 1'b1;
            3: wr_err = 1'b1;
            4: prog_done = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        wake = 0; stop_cmd = 0; wr_err = 0; prog_done = 0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int k, first_bs;
        bit quiet;
        void'($urandom(1234));
        fill_mem();
        mem[0] = mk_cfg(3, 0, 0, 0, 0, 0);

        // reset state
        @(negedge clk);
        chk(!mod_en && !term_active && !tx_bit && !bit_start, "R1 reset outputs",
            {mod_en, term_active, tx_bit}, 0);

        // R1 start-up window and first bit period
        do_reset();
        quiet = 1; first_bs = -1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (i <= 255 && (mod_en || bit_start)) quiet = 0;
            if (bit_start && first_bs < 0) first_bs = i;
        end
        chk(quiet, "R1 silent during init", 1, 0);
        chk(first_bs == 258, "R1 first bit period edge", first_bs, 258);
        wait_syms(200, "R3 capture");
        build_exp(1, 3, 0, 0, 0, 200);
        compare(200, "R3 block order and bit order");

        // R2 gap during init restarts
        do_reset();
        repeat (150) @(negedge clk);
        gap = 1'b1; @(negedge clk); gap = 1'b0;
        quiet = 1; first_bs = -1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (i <= 240 && mod_en) quiet = 0;
            if (bit_start && first_bs < 0) first_bs = i;
        end
        chk(quiet, "R2 restart keeps modulation off", 0, 1);
        chk(first_bs > 250, "R2 restart delays stream", first_bs, 258);

        // R5 R6 terminators
        fill_mem();
        mem[0] = mk_cfg(2, 1, 1, 0, 0, 0);
        do_reset();
        wait_syms(250, "R5 capture");
        build_exp(1, 2, 1, 1, 0, 250);
        compare(250, "R5 R6 block and sequence terminators");

        // R4 last block 0
        mem[0] = mk_cfg(0, 1, 1, 0, 0, 0);
        do_reset();
        wait_syms(150, "R4 capture");
        build_exp(0, 0, 1, 1, 0, 150);
        compare(150, "R4 block 0 only, no sequence terminator");

        // R8 rate
        mem[0] = mk_cfg(1, 0, 0, 0, 0, 2);
        do_reset();
        wait_syms(6, "R8 capture");
        chk(s_cyc[4] - s_cyc[3] == 32, "R8 rate code 2 period", s_cyc[4] - s_cyc[3], 32);
        mem[0] = mk_cfg(1, 0, 0, 0, 0, 4);
        do_reset();
        wait_syms(6, "R8 capture b");
        chk(s_cyc[5] - s_cyc[4] == 50, "R8 rate code 4 period", s_cyc[5] - s_cyc[4], 50);

        // R7 reload per block
        mem[0] = mk_cfg(3, 0, 0, 0, 0, 0);
        do_reset();
        wait_syms(50, "R7 capture a");
        mem[0] = mk_cfg(1, 0, 0, 0, 0, 0);
        wait_syms(250, "R7 capture b");
        k = 0;
        for (int i = 200; i < 250; i++) if (s_blk[i] != 1) k++;
        chk(k == 0, "R7 new last-block field applied", k, 0);

        // R9 answer-on-request
        mem[0] = mk_cfg(2, 0, 0, 1, 0, 0);
        boot(mem[0]);
        quiet = 1;
        for (int i = 0; i < 400; i++) begin @(negedge clk); if (mod_en) quiet = 0; end
        chk(quiet, "R9 quiet until wake", 0, 1);
        write_event(1, 0);
        wait_syms(40, "R9 capture");
        chk(mod_en, "R9 modulation after wake", mod_en, 1);
        build_exp(1, 2, 0, 0, 0, 40);
        compare(40, "R9 stream restarts at block 1");

        // R10 stop obeyed, then R13 write hold checked on the way
        write_event(2, 0);
        quiet = 1;
        for (int i = 0; i < 600; i++) begin @(negedge clk); if (mod_en) quiet = 0; end
        chk(quiet, "R10 stop holds modulation off", 0, 1);

        // R10 stop ignored
        boot(mk_cfg(2, 0, 0, 0, 1, 0));
        write_event(2, 0);
        repeat (10) @(negedge clk);
        chk(mod_en, "R10 ignored stop keeps modulation", mod_en, 1);

        // R13 gap hold and R12 write error
        fill_mem();
        boot(mk_cfg(3, 0, 0, 0, 0, 0));
        repeat (500) @(negedge clk);
        @(negedge clk); gap = 1'b1; @(negedge clk); gap = 1'b0;
        quiet = 1;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (mod_en || bit_start) quiet = 0; end
        chk(quiet, "R13 write hold silent", 0, 1);
        start_cap();
        wr_err = 1'b1; @(negedge clk); wr_err = 1'b0;
        wait_syms(40, "R12 capture");
        build_exp(1, 3, 0, 0, 0, 40);
        compare(40, "R12 resume at block 1");

        // R11 programming resume with leading terminator
        mem[0] = mk_cfg(3, 0, 1, 0, 0, 0);
        boot(mem[0]);
        write_event(4, 2);
        wait_syms(80, "R11 capture");
        build_exp(2, 3, 0, 1, 1, 80);
        compare(80, "R11 resume at programmed block");

        // R11 block 0 programmed: old mode for that block
        boot(mk_cfg(3, 0, 0, 0, 0, 0));
        @(negedge clk); gap = 1'b1; @(negedge clk); gap = 1'b0;
        mem[0] = mk_cfg(3, 1, 0, 0, 0, 0);
        start_cap();
        prog_blk = 3'd0; prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
        wait_syms(36, "R11 capture b");
        k = 0;
        for (int i = 0; i < 32; i++)
            if (s_term[i] || s_bit[i] !== mem[0][i+1] || s_blk[i] != 0) k++;
        chk(k == 0, "R11 block 0 sent under old mode", k, 0);
        chk(s_term[32] && s_bit[32] && s_term[33] && !s_bit[33],
            "R11 new mode terminator after block 0", {s_term[32], s_bit[32]}, 3);

        // random configurations (R3 R5 R6)
        for (int r = 0; r < 5; r++) begin
            int lb; bit bt, sq;
            lb = $urandom_range(1, 7); bt = 1'($urandom_range(0, 1)); sq = 1'($urandom_range(0, 1));
            fill_mem();
            mem[0] = mk_cfg(lb, bt, sq, 0, 0, 0);
            do_reset();
            wait_syms(160, "R3 random capture");
            build_exp(1, lb, bt, sq, 0, 160);
            compare(160, "R3 R5 R6 random configuration");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule